// File: doc/BRIEF.md
# Ethernet Controller Run/Halt Sequencer

This block owns the run/halt state of a small Ethernet MAC control subsystem. A register bus with a word address, write data, a write strobe and a combinational read path holds a run-enable bit, a halted status bit, a pending-event register, an event mask, transmit and receive configuration words, and two descriptor-ready flags. Four level outputs tell the transmit, receive, DMA and descriptor engines to stop. A one-cycle pulse tells the transmitter to finish the frame it is sending with a corrupted frame check.

There are two reset domains. The asynchronous active-low hard reset clears every register and leaves every output low. Software can also clear the run-enable bit. That clears only the descriptor-ready flags and stops the engines. The mask, the configuration words and the pending events keep their values. When a frame is still being sent, the block first pulses the bad-check request. It then holds the transmit abort until the transmitter reports idle, and only after that does it report the halted state.

Top module: `eth_enable_seq`

## Requirements
- R1: After hard reset, every register reads zero except the halted status bit, which reads 1. Every output is low.
- R2: The word addresses are: 0 control (bit 0 run-enable, read/write; bit 1 halted, read-only), 1 pending events, 2 event mask, 3 transmit configuration, 4 receive configuration, 5 receive-descriptor-ready (bit 0), 6 transmit-descriptor-ready (bit 0). Unused addresses read 0. The mask and both configuration words read back what was last written, and writes to them are accepted whether or not the block is enabled.
- R3: A high bit on `evt_i` sets the matching pending-event bit at the next clock edge. Writing ones to the event register clears the matching bits. Writing 0xFFFF_FFFF clears them all. If a set and a clear hit the same bit in the same cycle, the set wins.
- R4: `irq_o` is registered. It is high exactly when, at the previous clock edge, some pending-event bit and the matching mask bit were both set.
- R5: A write to a descriptor-ready flag loads bit 0 of the write data only while run-enable is 1. While run-enable is 0, both flags read 0.
- R6: Clearing run-enable while `tx_busy_i` is high has these effects:
  - In the cycle after the write, `bad_crc_o` is high for exactly one cycle, and all four stop outputs go high.
  - The halted bit stays 0 while `tx_busy_i` remains high.
  - The halted bit reads 1 in the cycle after an edge that samples `tx_busy_i` low.
- R7: Clearing run-enable while `tx_busy_i` is low raises the four stop outputs and the halted bit in the cycle after the write. No `bad_crc_o` pulse is produced.
- R8: Clearing run-enable clears both descriptor-ready flags in the same edge. It leaves the mask, both configuration words and the pending events unchanged.
- R9: Setting run-enable, whether from the halted state or while the transmitter is still draining, drops all four stop outputs and the halted bit in the same cycle that run-enable reads 1. The descriptor-ready flags stay 0 until software writes them again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| bus_addr | input | ADDR_W (3) | Register word address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| evt_i | input | DATA_W (32) | Event set pulses |
| tx_busy_i | input | 1 | Transmitter is sending a frame |
| irq_o | output | 1 | Registered interrupt request |
| tx_abort_o | output | 1 | Stop the transmit engine |
| rx_abort_o | output | 1 | Stop the receive engine |
| dma_stop_o | output | 1 | Terminate DMA activity |
| desc_halt_o | output | 1 | Halt the descriptor controller |
| bad_crc_o | output | 1 | One-cycle request to end the frame in flight with a bad frame check |

## Verification
The embedded properties check several invariants on every clock:
- the bad-check pulse never lasts longer than one cycle and only occurs while draining;
- draining continues only while the transmitter was busy at the previous edge;
- the flags stay zero while disabled;
- the configuration words survive a disable edge;
- the interrupt follows the masked events one cycle later;
- run-enable and halted are never both set.

Other behaviours only show up in the bench's scenarios against its cycle model:
- the exact cycle in which halted appears after the transmitter goes idle;
- that writes to the flags while disabled are lost;
- set-over-clear precedence on the event register;
- the release of every stop output when run-enable is set during a drain.

// File: rtl/eth_enable_seq_pkg.sv
package eth_enable_seq_pkg;

  localparam int unsigned MAP_AW = 3;

  localparam logic [MAP_AW-1:0] A_CTRL  = 3'd0;
  localparam logic [MAP_AW-1:0] A_EVT   = 3'd1;
  localparam logic [MAP_AW-1:0] A_MASK  = 3'd2;
  localparam logic [MAP_AW-1:0] A_TXCFG = 3'd3;
  localparam logic [MAP_AW-1:0] A_RXCFG = 3'd4;
  localparam logic [MAP_AW-1:0] A_RXRDY = 3'd5;
  localparam logic [MAP_AW-1:0] A_TXRDY = 3'd6;

  typedef enum logic [1:0] {
    S_OFF   = 2'd0,
    S_RUN   = 2'd1,
    S_DRAIN = 2'd2,
    S_HALT  = 2'd3
  } seq_state_t;

endpackage

// File: rtl/eth_enable_seq_fsm.sv
module eth_enable_seq_fsm
  import eth_enable_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_rise_i,
  input  logic en_fall_i,
  input  logic tx_busy_i,
  output logic stop_o,
  output logic bad_crc_o,
  output logic halted_o
);

  seq_state_t state_q, state_d;
  logic       crc_q, crc_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_OFF:   if (en_rise_i) state_d = S_RUN;
      S_RUN:   if (en_fall_i) state_d = tx_busy_i ? S_DRAIN : S_HALT;
      S_DRAIN: if (en_rise_i) state_d = S_RUN;
               else if (!tx_busy_i) state_d = S_HALT;
      S_HALT:  if (en_rise_i) state_d = S_RUN;
      default: state_d = S_OFF;
    endcase
  end

  assign crc_d = (state_q == S_RUN) && en_fall_i && tx_busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_OFF;
      crc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      crc_q   <= crc_d;
    end
  end

  assign stop_o    = (state_q == S_DRAIN) || (state_q == S_HALT);
  assign halted_o  = (state_q == S_OFF)   || (state_q == S_HALT);
  assign bad_crc_o = crc_q;

  // R6: the bad-check request lasts one cycle
  p_crc_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bad_crc_o |=> !bad_crc_o);

  // R6: the pulse only occurs while draining, with the stop asserted
  p_crc_in_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bad_crc_o |-> (stop_o && !halted_o));

  // R6: draining persists only while the transmitter was busy
  p_drain_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_o && !halted_o) |-> $past(tx_busy_i));

endmodule

// File: rtl/eth_enable_seq_regs.sv
module eth_enable_seq_regs
  import eth_enable_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] evt_i,
  input  logic              halted_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              en_o,
  output logic              en_rise_o,
  output logic              en_fall_o,
  output logic              irq_o
);

  localparam logic [ADDR_W-1:0] AD_CTRL  = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] AD_EVT   = ADDR_W'(A_EVT);
  localparam logic [ADDR_W-1:0] AD_MASK  = ADDR_W'(A_MASK);
  localparam logic [ADDR_W-1:0] AD_TXCFG = ADDR_W'(A_TXCFG);
  localparam logic [ADDR_W-1:0] AD_RXCFG = ADDR_W'(A_RXCFG);
  localparam logic [ADDR_W-1:0] AD_RXRDY = ADDR_W'(A_RXRDY);
  localparam logic [ADDR_W-1:0] AD_TXRDY = ADDR_W'(A_TXRDY);

  logic              en_q, en_d;
  logic [DATA_W-1:0] evt_q, evt_d, mask_q, txcfg_q, rxcfg_q;
  logic              rxrdy_q, rxrdy_d, txrdy_q, txrdy_d;
  logic              irq_q, irq_d;
  logic              wr_ctrl, wr_mask, wr_txcfg, wr_rxcfg, wr_evt;

  assign wr_ctrl  = we_i && (addr_i == AD_CTRL);
  assign wr_evt   = we_i && (addr_i == AD_EVT);
  assign wr_mask  = we_i && (addr_i == AD_MASK);
  assign wr_txcfg = we_i && (addr_i == AD_TXCFG);
  assign wr_rxcfg = we_i && (addr_i == AD_RXCFG);

  always_comb begin
    en_d      = wr_ctrl ? wdata_i[0] : en_q;
    en_rise_o = !en_q && en_d;
    en_fall_o = en_q && !en_d;
    evt_d     = (wr_evt ? (evt_q & ~wdata_i) : evt_q) | evt_i;
    rxrdy_d   = rxrdy_q;
    txrdy_d   = txrdy_q;
    if (en_q && we_i && addr_i == AD_RXRDY) rxrdy_d = wdata_i[0];
    if (en_q && we_i && addr_i == AD_TXRDY) txrdy_d = wdata_i[0];
    if (en_fall_o) begin
      rxrdy_d = 1'b0;
      txrdy_d = 1'b0;
    end
    irq_d = |(evt_q & mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      evt_q   <= '0;
      mask_q  <= '0;
      txcfg_q <= '0;
      rxcfg_q <= '0;
      rxrdy_q <= 1'b0;
      txrdy_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      en_q    <= en_d;
      evt_q   <= evt_d;
      rxrdy_q <= rxrdy_d;
      txrdy_q <= txrdy_d;
      irq_q   <= irq_d;
      if (wr_mask)  mask_q  <= wdata_i;
      if (wr_txcfg) txcfg_q <= wdata_i;
      if (wr_rxcfg) rxcfg_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      AD_CTRL:  rdata_o[1:0] = {halted_i, en_q};
      AD_EVT:   rdata_o = evt_q;
      AD_MASK:  rdata_o = mask_q;
      AD_TXCFG: rdata_o = txcfg_q;
      AD_RXCFG: rdata_o = rxcfg_q;
      AD_RXRDY: rdata_o[0] = rxrdy_q;
      AD_TXRDY: rdata_o[0] = txrdy_q;
      default:  rdata_o = '0;
    endcase
  end

  assign en_o  = en_q;
  assign irq_o = irq_q;

  // R5: flags stay clear while disabled
  p_flags_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!rxrdy_q && !txrdy_q));

  // R8: a disable edge keeps the configuration words
  p_cfg_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> ($stable(txcfg_q) && $stable(rxcfg_q) && $stable(mask_q)));

  // R4: interrupt follows the masked events one cycle later
  p_irq_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|(evt_q & mask_q)));

endmodule

// File: rtl/eth_enable_seq.sv
module eth_enable_seq
  import eth_enable_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] evt_i,
  input  logic              tx_busy_i,
  output logic              irq_o,
  output logic              tx_abort_o,
  output logic              rx_abort_o,
  output logic              dma_stop_o,
  output logic              desc_halt_o,
  output logic              bad_crc_o
);

  logic en, en_rise, en_fall, halted, stop;

  eth_enable_seq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_i    (bus_addr),
    .wdata_i   (bus_wdata),
    .we_i      (bus_we),
    .evt_i     (evt_i),
    .halted_i  (halted),
    .rdata_o   (bus_rdata),
    .en_o      (en),
    .en_rise_o (en_rise),
    .en_fall_o (en_fall),
    .irq_o     (irq_o)
  );

  eth_enable_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_rise_i (en_rise),
    .en_fall_i (en_fall),
    .tx_busy_i (tx_busy_i),
    .stop_o    (stop),
    .bad_crc_o (bad_crc_o),
    .halted_o  (halted)
  );

  assign tx_abort_o  = stop;
  assign rx_abort_o  = stop;
  assign dma_stop_o  = stop;
  assign desc_halt_o = stop;

  // R9: run-enable and halted are never reported together
  p_en_not_halted_r9: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (!halted && !tx_abort_o));

endmodule

// File: tb/eth_enable_seq_test.sv
`timescale 1ns/1ps
module eth_enable_seq_test;

  localparam int DW = 32;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic [DW-1:0] evt_i = '0;
  logic          tx_busy_i = 1'b0;
  logic irq_o, tx_abort_o, rx_abort_o, dma_stop_o, desc_halt_o, bad_crc_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  eth_enable_seq #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .evt_i(evt_i), .tx_busy_i(tx_busy_i),
    .irq_o(irq_o), .tx_abort_o(tx_abort_o), .rx_abort_o(rx_abort_o),
    .dma_stop_o(dma_stop_o), .desc_halt_o(desc_halt_o), .bad_crc_o(bad_crc_o)
  );

  // behavioural reference: 0 off, 1 run, 2 drain, 3 halt
  int          m_st;
  bit          m_en, m_crc, m_rx, m_tx, m_irq;
  bit [DW-1:0] m_evt, m_mask, m_txc, m_rxc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_en = 0; m_crc = 0; m_rx = 0; m_tx = 0; m_irq = 0;
      m_evt = 0; m_mask = 0; m_txc = 0; m_rxc = 0;
    end else begin
      bit ne, fall, rise;
      int ns;
      m_irq = |(m_evt & m_mask);
      if (bus_we && bus_addr == 1) m_evt = m_evt & ~bus_wdata;
      m_evt = m_evt | evt_i;
      ne = (bus_we && bus_addr == 0) ? bus_wdata[0] : m_en;
      fall = m_en && !ne;
      rise = !m_en && ne;
      ns = m_st;
      if (rise) ns = 1;
      else if (m_st == 1 && fall) ns = tx_busy_i ? 2 : 3;
      else if (m_st == 2 && !tx_busy_i) ns = 3;
      m_crc = (m_st == 1) && fall && tx_busy_i;
      if (m_en && bus_we && bus_addr == 5) m_rx = bus_wdata[0];
      if (m_en && bus_we && bus_addr == 6) m_tx = bus_wdata[0];
      if (fall) begin m_rx = 0; m_tx = 0; end
      if (bus_we && bus_addr == 2) m_mask = bus_wdata;
      if (bus_we && bus_addr == 3) m_txc = bus_wdata;
      if (bus_we && bus_addr == 4) m_rxc = bus_wdata;
      m_en = ne;
      m_st = ns;
    end
  end

  function automatic bit [DW-1:0] m_read(input int a);
    case (a)
      0: m_read = {30'd0, (m_st == 0 || m_st == 3), m_en};
      1: m_read = m_evt;
      2: m_read = m_mask;
      3: m_read = m_txc;
      4: m_read = m_rxc;
      5: m_read = {31'd0, m_rx};
      6: m_read = {31'd0, m_tx};
      default: m_read = '0;
    endcase
  endfunction

  task automatic cmp(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) if (rst_n && !done) begin
    bit stp;
    stp = (m_st == 2 || m_st == 3);
    cmp("R4 irq", irq_o, m_irq);
    cmp("R6 bad_crc", bad_crc_o, m_crc);
    cmp("R7 tx_abort", tx_abort_o, stp);
    cmp("R7 rx_abort", rx_abort_o, stp);
    cmp("R7 dma_stop", dma_stop_o, stp);
    cmp("R7 desc_halt", desc_halt_o, stp);
    cmp("R2 rdata", bus_rdata, m_read(int'(bus_addr)));
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
    step(1);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input int a, input logic [DW-1:0] exp);
    bus_addr = AW'(a);
    #1;
    cmp(tag, bus_rdata, exp);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    // R1 reset state
    cmp("R1 outputs", {irq_o, tx_abort_o, rx_abort_o, dma_stop_o, desc_halt_o, bad_crc_o}, 0);
    rd_chk("R1 ctrl halted", 0, 32'h2);
    rd_chk("R1 mask", 2, 0);
    rst_n = 1'b1;
    step(2);
    // R2 read/write while disabled
    wr(2, 32'h0000_00F0);
    wr(3, 32'hA5A5_1234);
    wr(4, 32'h0BAD_F00D);
    rd_chk("R2 mask", 2, 32'h0000_00F0);
    rd_chk("R2 txcfg", 3, 32'hA5A5_1234);
    rd_chk("R2 rxcfg", 4, 32'h0BAD_F00D);
    rd_chk("R2 unused", 7, 0);
    // R5 flag write while disabled is lost
    wr(5, 1); wr(6, 1);
    rd_chk("R5 rx flag off", 5, 0);
    rd_chk("R5 tx flag off", 6, 0);
    // R3/R4 events and interrupt
    evt_i = 32'h0000_0010; step(1); evt_i = 0;
    rd_chk("R3 event set", 1, 32'h10);
    cmp("R4 irq not yet", irq_o, 0);
    step(1);
    cmp("R4 irq raised", irq_o, 1);
    evt_i = 32'h0000_0003; step(1); evt_i = 0;
    bus_addr = 1; bus_wdata = 32'h0000_0001; bus_we = 1; evt_i = 32'h1;
    step(1); bus_we = 0; evt_i = 0;
    rd_chk("R3 set beats clear", 1, 32'h13);
    wr(2, 0);
    step(1);
    cmp("R4 masked off", irq_o, 0);
    wr(1, 32'hFFFF_FFFF);
    rd_chk("R3 w1c all", 1, 0);
    wr(2, 32'h0000_0F00);
    // enable and set flags
    wr(0, 1);
    cmp("R9 enabled no stop", tx_abort_o, 0);
    rd_chk("R9 ctrl run", 0, 32'h1);
    wr(5, 1); wr(6, 1);
    rd_chk("R5 rx flag on", 5, 1);
    rd_chk("R5 tx flag on", 6, 1);
    evt_i = 32'h0000_0100; step(1); evt_i = 0;
    // R6 disable with transmitter busy
    tx_busy_i = 1'b1;
    wr(0, 0);
    cmp("R6 crc pulse", bad_crc_o, 1);
    cmp("R6 abort", tx_abort_o, 1);
    rd_chk("R6 not halted", 0, 32'h0);
    rd_chk("R8 rx flag cleared", 5, 0);
    rd_chk("R8 txcfg kept", 3, 32'hA5A5_1234);
    rd_chk("R8 event kept", 1, 32'h100);
    step(1);
    cmp("R6 crc one cycle", bad_crc_o, 0);
    step(3);
    rd_chk("R6 still draining", 0, 32'h0);
    tx_busy_i = 1'b0;
    rd_chk("R6 halted not before edge", 0, 32'h0);
    step(1);
    rd_chk("R6 halted after idle", 0, 32'h2);
    cmp("R6 abort held", tx_abort_o, 1);
    // R9 re-enable
    wr(0, 1);
    cmp("R9 release", {tx_abort_o, rx_abort_o, dma_stop_o, desc_halt_o}, 0);
    rd_chk("R9 flags stay off", 6, 0);
    // R7 disable while idle
    wr(0, 0);
    cmp("R7 stop idle", desc_halt_o, 1);
    cmp("R7 no pulse", bad_crc_o, 0);
    rd_chk("R7 halted now", 0, 32'h2);
    // R9 re-enable during drain
    wr(0, 1);
    tx_busy_i = 1'b1;
    wr(6, 1);
    wr(0, 0);
    step(1);
    wr(0, 1);
    cmp("R9 release during drain", {tx_abort_o, dma_stop_o}, 0);
    rd_chk("R9 tx flag cleared", 6, 0);
    tx_busy_i = 1'b0;
    step(4);
    finish_run();
  end

endmodule